// File: doc/BRIEF.md
# ECC Error Capture Logger

This block sits behind a memory ECC checker and records one failing read so that software can inspect it later. On each checked read the checker presents a valid strobe, a single-bit error strobe, a multi-bit error strobe, the syndrome, the failing address, two block indicator bits and a flag that says whether a scrubber or the bus master made the access. When the logger accepts an error, it sets a sticky logged flag and stores all the attributes of that read together.

Capture priority is asymmetric. A held single-bit entry blocks further single-bit errors, but a later multi-bit error still replaces it. A held multi-bit entry freezes the log until software clears the flag. Errors seen on scrub accesses are only accepted when software has enabled that. An interrupt output is raised while the flag is set and the interrupt is enabled.

Software uses a two-word register window. The control/status word is at offset 0: bit 0 is the logged flag (write one to clear), bit 1 is the scrub-logging enable, bit 2 is the interrupt enable, bit 3 is the stored source (read-only), bit 4 is the stored multi-bit type (read-only), bit 5 is the stored single-bit type (read-only), bits 7:6 are the stored block bits (read-only) and bits 15:8 are the stored syndrome (read-only). All other bits read as zero. The stored failing address is at offset 1. Reads are combinational from `reg_addr_i`.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, both register words read zero and `irq_o` is low. The logged flag (status bit 0) sets when a checked read (`chk_valid_i` high) reports a single-bit or a multi-bit error. Only such a capture can set it.
- R2: Writing offset 0 with bit 0 equal to 1 clears the logged flag. Writing with bit 0 equal to 0 leaves the flag unchanged. Such a write also loads bit 1 and bit 2.
- R3: While the held entry is a multi-bit error (bit 4 set) and the flag is set, no error of either kind changes the flag or any stored attribute.
- R4: While the held entry is a single-bit error and the flag is set, a further single-bit error changes nothing.
- R5: While the held entry is a single-bit error, a multi-bit error is captured and replaces every stored attribute.
- R6: A capture stores all attributes of that read together. Bit 3 is 1 for a scrubber access and 0 for a bus-master access. Bits 4 and 5 give the error type, bits 7:6 the block bits and bits 15:8 the syndrome, and offset 1 holds the address.
- R7: When bit 1 is clear, errors on scrub accesses are ignored entirely. When bit 1 is set, they are captured like any other error.
- R8: A read that reports a single-bit and a multi-bit error at once is stored as a multi-bit error: bit 4 is 1 and bit 5 is 0.
- R9: If a capture and a write-one-to-clear happen in the same cycle, the capture wins and the flag stays set.
- R10: Clearing the flag leaves the stored attributes unchanged until the next capture.
- R11: `irq_o` is high exactly while the logged flag and the interrupt enable (bit 2) are both set.
- R12: Error strobes presented while `chk_valid_i` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chk_valid_i | input | 1 | A checked read result is present |
| sbe_i | input | 1 | Single-bit error on this read |
| mbe_i | input | 1 | Multi-bit error on this read |
| scrub_i | input | 1 | 1 = scrubber access, 0 = bus-master access |
| syndrome_i | input | 8 | ECC syndrome |
| addr_i | input | 32 | Failing address |
| blk_i | input | 2 | Block indicator bits |
| reg_addr_i | input | 1 | Register word select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The capture path is tested with a series of error sequences, each starting from a known held state. A single-bit error following a held single-bit entry shows whether blocking depends on the stored error type. A multi-bit error following the same entry shows whether an overwrite replaces every attribute. Errors of both kinds following a held multi-bit entry show whether the log is frozen. Further patterns check the remaining cases: scrub errors with the enable off and on, to show the filter and the source bit; a read with both strobes set, to check type priority; a capture in the same cycle as a clear; and strobes without a valid read.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  parameter int unsigned SYND_W = 8;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned BLK_W  = 2;
  parameter int unsigned REG_W  = 32;
  parameter int unsigned REG_AW = 1;

  localparam logic [REG_AW-1:0] CTRL_OFS = REG_AW'(0);
  localparam logic [REG_AW-1:0] ADDR_OFS = REG_AW'(1);

  localparam int unsigned B_LOG = 0;
  localparam int unsigned B_SEN = 1;
  localparam int unsigned B_IEN = 2;
  localparam int unsigned B_SRC = 3;
  localparam int unsigned B_MBE = 4;
  localparam int unsigned B_SBE = 5;
  localparam int unsigned B_BLK = 6;
  localparam int unsigned B_SYN = B_BLK + BLK_W;

  typedef struct packed {
    logic              scrub;
    logic              mbe;
    logic              sbe;
    logic [BLK_W-1:0]  blk;
    logic [SYND_W-1:0] syn;
    logic [ADDR_W-1:0] addr;
  } err_attr_t;
endpackage

// File: rtl/ecc_log_filter.sv
module ecc_log_filter
  import ecc_log_pkg::*;
(
  input  logic              chk_valid_i,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic              scrub_i,
  input  logic [SYND_W-1:0] syndrome_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              scrub_en_i,
  input  logic              logged_i,
  input  logic              held_mbe_i,
  output logic              take_o,
  output err_attr_t         attr_o
);
  logic err_seen;
  logic src_ok;
  logic room;

  assign err_seen = chk_valid_i & (sbe_i | mbe_i);
  assign src_ok   = ~scrub_i | scrub_en_i;
  // empty log, or a held single-bit entry being upgraded by a multi-bit error
  assign room     = ~logged_i | (~held_mbe_i & mbe_i);
  assign take_o   = err_seen & src_ok & room;

  always_comb begin
    attr_o       = '0;
    attr_o.scrub = scrub_i;
    attr_o.mbe   = mbe_i;
    attr_o.sbe   = sbe_i & ~mbe_i;
    attr_o.blk   = blk_i;
    attr_o.syn   = syndrome_i;
    attr_o.addr  = addr_i;
  end
endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store
  import ecc_log_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      take_i,
  input  logic      clr_i,
  input  err_attr_t attr_i,
  output logic      logged_o,
  output err_attr_t attr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      logged_o <= 1'b0;
      attr_o   <= '0;
    end else begin
      if (take_i) begin
        logged_o <= 1'b1;
        attr_o   <= attr_i;
      end else if (clr_i) begin
        logged_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              logged_i,
  input  err_attr_t         attr_i,
  output logic              scrub_en_o,
  output logic              irq_en_o,
  output logic              clr_o,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic ctrl_wr;

  assign ctrl_wr = reg_we_i & (reg_addr_i == CTRL_OFS);
  assign clr_o   = ctrl_wr & reg_wdata_i[B_LOG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scrub_en_o <= 1'b0;
      irq_en_o   <= 1'b0;
    end else if (ctrl_wr) begin
      scrub_en_o <= reg_wdata_i[B_SEN];
      irq_en_o   <= reg_wdata_i[B_IEN];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_OFS) begin
      reg_rdata_o[ADDR_W-1:0] = attr_i.addr;
    end else begin
      reg_rdata_o[B_LOG]            = logged_i;
      reg_rdata_o[B_SEN]            = scrub_en_o;
      reg_rdata_o[B_IEN]            = irq_en_o;
      reg_rdata_o[B_SRC]            = attr_i.scrub;
      reg_rdata_o[B_MBE]            = attr_i.mbe;
      reg_rdata_o[B_SBE]            = attr_i.sbe;
      reg_rdata_o[B_BLK +: BLK_W]   = attr_i.blk;
      reg_rdata_o[B_SYN +: SYND_W]  = attr_i.syn;
    end
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_valid_i,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic              scrub_i,
  input  logic [SYND_W-1:0] syndrome_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic      take;
  logic      clr;
  logic      logged_q;
  logic      scrub_en;
  logic      irq_en;
  err_attr_t attr_new;
  err_attr_t attr_q;

  ecc_log_filter u_filter (
    .chk_valid_i (chk_valid_i),
    .sbe_i       (sbe_i),
    .mbe_i       (mbe_i),
    .scrub_i     (scrub_i),
    .syndrome_i  (syndrome_i),
    .addr_i      (addr_i),
    .blk_i       (blk_i),
    .scrub_en_i  (scrub_en),
    .logged_i    (logged_q),
    .held_mbe_i  (attr_q.mbe),
    .take_o      (take),
    .attr_o      (attr_new)
  );

  ecc_log_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .clr_i    (clr),
    .attr_i   (attr_new),
    .logged_o (logged_q),
    .attr_o   (attr_q)
  );

  ecc_log_regif u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .logged_i    (logged_q),
    .attr_i      (attr_q),
    .scrub_en_o  (scrub_en),
    .irq_en_o    (irq_en),
    .clr_o       (clr),
    .reg_rdata_o (reg_rdata_o)
  );

  assign irq_o = logged_q & irq_en;
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
  import ecc_log_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chk_valid_i,
  input logic              sbe_i,
  input logic              mbe_i,
  input logic              scrub_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              irq_o,
  input logic              logged_i,
  input logic              scrub_en_i,
  input err_attr_t         attr_i
);
  logic w1c;
  logic err_any;

  assign w1c     = reg_we_i && (reg_addr_i == CTRL_OFS) && reg_wdata_i[B_LOG];
  assign err_any = chk_valid_i && (sbe_i || mbe_i);

  AST_SET_BY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(logged_i) |-> $past(err_any)) else $error("flag set without error"); // R1
  AST_W0_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logged_i && !w1c) |=> logged_i) else $error("flag dropped without w1c"); // R2
  AST_MBE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logged_i && attr_i.mbe) |=> $stable(attr_i)) else $error("frozen log changed"); // R3
  AST_SBE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logged_i && !mbe_i) |=> $stable(attr_i)) else $error("held entry replaced"); // R4
  AST_SCRUB_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scrub_en_i && scrub_i && !logged_i) |=> !logged_i) else $error("scrub error logged"); // R7
  AST_ONE_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logged_i |-> !(attr_i.mbe && attr_i.sbe)) else $error("both types stored"); // R8
  AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_any && !scrub_i && !logged_i && w1c) |=> logged_i) else $error("clear beat capture"); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> logged_i) else $error("irq without flag"); // R11
  AST_VALID_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_valid_i && !logged_i) |=> !logged_i) else $error("capture without valid"); // R12
endmodule

bind ecc_err_logger ecc_err_logger_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chk_valid_i (chk_valid_i),
  .sbe_i       (sbe_i),
  .mbe_i       (mbe_i),
  .scrub_i     (scrub_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .logged_i    (logged_q),
  .scrub_en_i  (scrub_en),
  .attr_i      (attr_q)
);

// File: tb/ecc_err_logger_test.sv
module ecc_err_logger_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        chk_valid_i = 1'b0;
  logic        sbe_i = 1'b0;
  logic        mbe_i = 1'b0;
  logic        scrub_i = 1'b0;
  logic [7:0]  syndrome_i = '0;
  logic [31:0] addr_i = '0;
  logic [1:0]  blk_i = '0;
  logic [0:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  ecc_err_logger uut (
    .clk_i, .rst_ni, .chk_valid_i, .sbe_i, .mbe_i, .scrub_i, .syndrome_i,
    .addr_i, .blk_i, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] stat(input logic lg, input logic sen, input logic ien,
                                       input logic src, input logic mb, input logic sb,
                                       input logic [1:0] bk, input logic [7:0] sy);
    return {16'h0, sy, bk, sb, mb, src, ien, sen, lg};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic expect_regs(input string req, input logic [31:0] st, input logic [31:0] ad);
    logic [31:0] d;
    rd(1'b0, d); check(req, d, st);
    rd(1'b1, d); check(req, d, ad);
    reg_addr_i = 1'b0;
  endtask

  // one checked read; optionally a control write in the same cycle
  task automatic err_cyc(input logic v, input logic sb, input logic mb, input logic sc,
                         input logic [7:0] sy, input logic [31:0] ad, input logic [1:0] bk,
                         input logic we, input logic [31:0] wd);
    @(negedge clk_i);
    chk_valid_i = v; sbe_i = sb; mbe_i = mb; scrub_i = sc;
    syndrome_i = sy; addr_i = ad; blk_i = bk;
    reg_addr_i = 1'b0; reg_we_i = we; reg_wdata_i = wd;
    @(negedge clk_i);
    chk_valid_i = 1'b0; sbe_i = 1'b0; mbe_i = 1'b0; scrub_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic err(input logic sb, input logic mb, input logic sc, input logic [7:0] sy,
                     input logic [31:0] ad, input logic [1:0] bk);
    err_cyc(1'b1, sb, mb, sc, sy, ad, bk, 1'b0, 32'h0);
  endtask

  task automatic wr_ctrl(input logic [31:0] wd);
    err_cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 32'h0, 2'b0, 1'b1, wd);
  endtask

  task automatic t_reset;
    expect_regs("R1 reset", 32'h0, 32'h0);
    check("R1 reset irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_sbe_capture;
    wr_ctrl(32'h4);
    check("R11 irq off while empty", {31'h0, irq_o}, 32'h0);
    err(1'b1, 1'b0, 1'b0, 8'h11, 32'hA000_0001, 2'b01);
    expect_regs("R1 R6 sbe capture", stat(1,0,1,0,0,1,2'b01,8'h11), 32'hA000_0001);
    check("R11 irq on", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_sbe_block;
    err(1'b1, 1'b0, 1'b0, 8'h22, 32'hA000_0002, 2'b10);
    expect_regs("R4 sbe blocked", stat(1,0,1,0,0,1,2'b01,8'h11), 32'hA000_0001);
  endtask

  task automatic t_w0;
    wr_ctrl(32'h4);
    expect_regs("R2 write zero keeps flag", stat(1,0,1,0,0,1,2'b01,8'h11), 32'hA000_0001);
  endtask

  task automatic t_mbe_over;
    err(1'b0, 1'b1, 1'b0, 8'h33, 32'hA000_0003, 2'b10);
    expect_regs("R5 mbe overwrites", stat(1,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
  endtask

  task automatic t_mbe_freeze;
    err(1'b0, 1'b1, 1'b0, 8'h44, 32'hA000_0004, 2'b01);
    expect_regs("R3 mbe frozen vs mbe", stat(1,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
    err(1'b1, 1'b0, 1'b0, 8'h45, 32'hA000_0005, 2'b11);
    expect_regs("R3 mbe frozen vs sbe", stat(1,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
  endtask

  task automatic t_clear;
    wr_ctrl(32'h5);
    expect_regs("R2 R10 w1c keeps attrs", stat(0,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
    check("R11 irq drops", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_scrub;
    err(1'b1, 1'b0, 1'b1, 8'h55, 32'hA000_0006, 2'b11);
    expect_regs("R7 scrub filtered", stat(0,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
    err(1'b0, 1'b1, 1'b1, 8'h56, 32'hA000_0007, 2'b11);
    expect_regs("R7 scrub mbe filtered", stat(0,0,1,0,1,0,2'b10,8'h33), 32'hA000_0003);
    wr_ctrl(32'h6);
    err(1'b1, 1'b0, 1'b1, 8'h57, 32'hA000_0008, 2'b11);
    expect_regs("R7 R6 scrub logged src", stat(1,1,1,1,0,1,2'b11,8'h57), 32'hA000_0008);
  endtask

  task automatic t_both;
    wr_ctrl(32'h7);
    err(1'b1, 1'b1, 1'b0, 8'h66, 32'hA000_0009, 2'b00);
    expect_regs("R8 dual strobe is mbe", stat(1,1,1,0,1,0,2'b00,8'h66), 32'hA000_0009);
  endtask

  task automatic t_cap_wins;
    wr_ctrl(32'h7);
    err_cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h77, 32'hA000_000A, 2'b01, 1'b1, 32'h7);
    expect_regs("R9 capture beats clear", stat(1,1,1,0,0,1,2'b01,8'h77), 32'hA000_000A);
  endtask

  task automatic t_valid;
    wr_ctrl(32'h7);
    err_cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h88, 32'hA000_000B, 2'b10, 1'b0, 32'h0);
    expect_regs("R12 no valid no capture", stat(0,1,1,0,0,1,2'b01,8'h77), 32'hA000_000A);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_sbe_capture;
    t_sbe_block;
    t_w0;
    t_mbe_over;
    t_mbe_freeze;
    t_clear;
    t_scrub;
    t_both;
    t_cap_wins;
    t_valid;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule